// File: doc/BRIEF.md
# Boot Chip-Select Decoder with Programmable Wait States

This block watches a 24-bit processor bus and drives an active-low chip-select for the memory that holds the boot code. Each access is compared against a programmed base address and a window size. The access must also pass four qualifiers: the access space taken from the function code, the transfer direction, the byte lanes and the strobe timing. When all of them pass, the select goes low, and an active-low transfer acknowledge is produced once a programmed number of wait states has elapsed.

The block is usable straight out of reset. The base is zero and the window is 512 KB, so the first fetch after reset already selects the boot memory. The reset state allows supervisor accesses only, of either direction and either byte lane, with address-strobe timing and thirteen wait states. Software can later rewrite the base and option fields through a one-cycle write port. A new setting is latched into the comparison only while the address strobe is negated, so it governs the following bus cycle and never the one in progress.

Outputs are registered. The select reflects the bus inputs sampled at the previous clock edge. The acknowledge counts clock edges from the first edge that samples the address strobe low.

Top module: `bootsel_decoder`

## Requirements
- R1: While reset is held, csN and dtackN are both high. After reset, a supervisor read (fc=6) of address 0x000000 on both lanes drives csN low at the first clock edge that samples asN low.
- R2: In the reset state the window is 0x000000 to 0x07FFFF: 0x07FFFF selects and 0x080000 does not.
- R3: dtackN goes low at the clock edge that is N edges after the first edge sampling asN low, where N is the active wait count (cfgData[3:0] of an option write; reset value 13). dtackN stays low while the access keeps matching.
- R4: The first clock edge that samples asN high drives both csN and dtackN high.
- R5: In the reset state a user access (fc 0 to 3) and a CPU-space access (fc=7) never drive csN low.
- R6: The size code (option bits [7:4]) selects a window of 2^(11+code) bytes, and codes of 9 and above give 1 MB. Base bits (write with cfgSel=0, address in cfgData[23:11]) below the window size are ignored in the comparison.
- R7: Lane enable (option bits [9:8]: bit 9 is upper, bit 8 is lower) and direction enable (option bits [11:10]: bit 10 allows reads with rdWr=1, bit 11 allows writes) must admit the access, or csN stays high. Reset allows both lanes and both directions.
- R8: With option bit 12 set, csN goes low only at an edge that samples both asN and dsN low. The acknowledge still counts from asN.
- R9: The space field (option bits [14:13]) takes the codes 00 CPU (fc=7 only), 01 user (fc<4), 10 supervisor (fc 4 to 6) and 11 either (fc not 7). The level field (bits [17:15]) and the autovector bit (bit 18) are ignored unless the space is CPU. In CPU space a nonzero level must equal busAddr[3:1], and a set autovector bit keeps dtackN high.
- R10: A write to the base or option fields during an access leaves that access unchanged and governs the next access.
- R11: A wait count of 0 asserts dtackN at the same edge as csN. A wait count of 15 never asserts dtackN, although csN still asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | One-cycle write strobe for the configuration fields |
| cfgSel | input | 1 | 0 writes the base address, 1 writes the option fields |
| cfgData | input | 24 | Write data: address bits for the base, packed fields for the options |
| busAddr | input | 24 | Bus address |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rdWr | input | 1 | 1 is a read, 0 is a write |
| upperEn | input | 1 | Upper byte lane in use |
| lowerEn | input | 1 | Lower byte lane in use |
| fc | input | 3 | Function code giving the access space |
| csN | output | 1 | Boot chip-select, active low |
| dtackN | output | 1 | Internally timed transfer acknowledge, active low |

## Verification
The hardest case to reach is a configuration write that lands inside an open bus cycle. The old setting must keep governing the wait count, and the new one must govern only the next cycle. The bus task injects the write at a fixed edge while the address strobe is held low, then runs a second cycle and compares both acknowledge times. The CPU-space level and autovector qualifiers are also awkward to reach, because they matter only after the space field is reprogrammed. The stimulus therefore visits them in sequence, with the level field set both to a matching value and to a mismatching one.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

  localparam int OPT_W  = 19;
  localparam int WAIT_W = 4;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    SP_CPU    = 2'b00,
    SP_USER   = 2'b01,
    SP_SUPER  = 2'b10,
    SP_EITHER = 2'b11
  } space_e;

  // Packed so that bit 0 of the option write lands in waitCount[0].
  typedef struct packed {
    logic              autoVec;
    logic [2:0]        irqLevel;
    space_e            space;
    logic              dsTiming;
    logic [1:0]        dirEn;
    logic [1:0]        laneEn;
    logic [CODE_W-1:0] sizeCode;
    logic [WAIT_W-1:0] waitCount;
  } optFields_t;

  localparam optFields_t OPT_RESET = '{
    autoVec:   1'b0,
    irqLevel:  3'd0,
    space:     SP_SUPER,
    dsTiming:  1'b0,
    dirEn:     2'b11,
    laneEn:    2'b11,
    sizeCode:  4'd8,
    waitCount: 4'd13
  };

  typedef struct packed {
    logic capture;
    logic cntClr;
    logic cntInc;
    logic ackOn;
    logic ackOff;
    logic selOn;
  } ctlStrobes_t;

  typedef struct packed {
    logic hit;
    logic strobeOn;
    logic waitDone;
    logic ackOk;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ACKED,
    ST_MISS
  } busState_e;

endpackage

// File: rtl/bootsel_dp.sv
module bootsel_dp
  import bootsel_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MIN_LOG2  = 11,
  parameter int NUM_SIZES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rdWr,
  input  logic              upperEn,
  input  logic              lowerEn,
  input  logic [2:0]        fc,
  input  ctlStrobes_t       strb,
  output dpStatus_t         stat,
  output logic              csN,
  output logic              dtackN
);

  localparam int CMP_W = ADDR_W - MIN_LOG2;

  logic [CMP_W-1:0]  progBase;
  logic [CMP_W-1:0]  actBase;
  optFields_t        progOpt;
  optFields_t        actOpt;
  logic [WAIT_W-1:0] waitCnt;

  // Programmed copy: written by software at any time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progBase <= '0;
      progOpt  <= OPT_RESET;
    end else if (cfgWrEn) begin
      if (cfgSel) progOpt  <= optFields_t'(cfgData[OPT_W-1:0]);
      else        progBase <= cfgData[ADDR_W-1:MIN_LOG2];
    end
  end

  // Active copy: only reloaded between bus cycles.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBase <= '0;
      actOpt  <= OPT_RESET;
    end else if (strb.capture) begin
      actBase <= progBase;
      actOpt  <= progOpt;
    end
  end

  // One compare mask per window size.
  logic [CMP_W-1:0] sizeMask [NUM_SIZES];
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    assign sizeMask[g] = {CMP_W{1'b1}} << g;
  end

  logic [CODE_W-1:0] codeIdx;
  logic [CMP_W-1:0]  selMask;

  always_comb begin
    if (actOpt.sizeCode >= CODE_W'(NUM_SIZES)) codeIdx = CODE_W'(NUM_SIZES - 1);
    else                                       codeIdx = actOpt.sizeCode;
  end

  always_comb begin
    selMask = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (codeIdx == CODE_W'(i)) selMask = sizeMask[i];
    end
  end

  logic addrHit, spaceHit, dirHit, laneHit;

  assign addrHit = ((busAddr[ADDR_W-1:MIN_LOG2] ^ actBase) & selMask) == '0;

  always_comb begin
    case (actOpt.space)
      SP_CPU:    spaceHit = (fc == 3'b111) &&
                            ((actOpt.irqLevel == 3'd0) || (busAddr[3:1] == actOpt.irqLevel));
      SP_USER:   spaceHit = !fc[2];
      SP_SUPER:  spaceHit = fc[2] && (fc != 3'b111);
      SP_EITHER: spaceHit = (fc != 3'b111);
    endcase
  end

  assign dirHit  = rdWr ? actOpt.dirEn[0] : actOpt.dirEn[1];
  assign laneHit = (upperEn & actOpt.laneEn[1]) | (lowerEn & actOpt.laneEn[0]);

  logic unusedAddrBits;
  assign unusedAddrBits = ^{busAddr[MIN_LOG2-1:4], busAddr[0]};

  assign stat.hit      = addrHit & spaceHit & dirHit & laneHit;
  assign stat.strobeOn = !asN && (!actOpt.dsTiming || !dsN);
  assign stat.waitDone = (waitCnt == actOpt.waitCount);
  assign stat.ackOk    = (actOpt.waitCount != '1) &&
                         !((actOpt.space == SP_CPU) && actOpt.autoVec);

  // Wait-state counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            waitCnt <= '0;
    else if (strb.cntClr) waitCnt <= '0;
    else if (strb.cntInc) waitCnt <= waitCnt + 1'b1;
  end

  // Registered strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN    <= 1'b1;
      dtackN <= 1'b1;
    end else begin
      csN <= !strb.selOn;
      if (strb.ackOn)       dtackN <= 1'b0;
      else if (strb.ackOff) dtackN <= 1'b1;
    end
  end

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> csN);

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> dtackN);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !asN |=> $stable({actBase, actOpt}));

  // R11
  no_ack_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actOpt.waitCount == '1) |=> dtackN);

  // R3
  ack_on_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> $past(stat.waitDone));

endmodule

// File: rtl/bootsel_ctrl.sv
module bootsel_ctrl
  import bootsel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        asN,
  input  dpStatus_t   stat,
  output ctlStrobes_t strb
);

  busState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb         = '0;
    nxt          = state;
    strb.capture = asN;
    strb.selOn   = stat.hit && stat.strobeOn;
    if (asN) begin
      strb.cntClr = 1'b1;
      strb.ackOff = 1'b1;
      nxt         = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_COUNT: begin
          if (!stat.hit) begin
            strb.cntClr = 1'b1;
            nxt         = ST_MISS;
          end else if (stat.waitDone && stat.ackOk) begin
            strb.ackOn = 1'b1;
            nxt        = ST_ACKED;
          end else begin
            strb.cntInc = !stat.waitDone;
            nxt         = ST_COUNT;
          end
        end
        ST_ACKED: begin
          if (!stat.hit) begin
            strb.ackOff = 1'b1;
            strb.cntClr = 1'b1;
            nxt         = ST_MISS;
          end
        end
        ST_MISS: begin
          nxt = ST_MISS;
        end
      endcase
    end
  end

  // R9
  no_ack_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stat.hit |-> !strb.ackOn);

  // R3
  ack_needs_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackOn |-> stat.waitDone);

endmodule

// File: rtl/bootsel_decoder.sv
module bootsel_decoder
  import bootsel_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MIN_LOG2  = 11,
  parameter int NUM_SIZES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rdWr,
  input  logic              upperEn,
  input  logic              lowerEn,
  input  logic [2:0]        fc,
  output logic              csN,
  output logic              dtackN
);

  ctlStrobes_t strb;
  dpStatus_t   stat;

  bootsel_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .asN  (asN),
    .stat (stat),
    .strb (strb)
  );

  bootsel_dp #(
    .ADDR_W    (ADDR_W),
    .MIN_LOG2  (MIN_LOG2),
    .NUM_SIZES (NUM_SIZES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .busAddr (busAddr),
    .asN     (asN),
    .dsN     (dsN),
    .rdWr    (rdWr),
    .upperEn (upperEn),
    .lowerEn (lowerEn),
    .fc      (fc),
    .strb    (strb),
    .stat    (stat),
    .csN     (csN),
    .dtackN  (dtackN)
  );

endmodule

// File: tb/bootsel_decoder_bench.sv
module bootsel_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [23:0] cfgData = '0;
  logic [23:0] busAddr = '0;
  logic        asN = 1'b1;
  logic        dsN = 1'b1;
  logic        rdWr = 1'b1;
  logic        upperEn = 1'b1;
  logic        lowerEn = 1'b1;
  logic [2:0]  fc = 3'd6;
  logic        csN, dtackN;

  int    checks = 0;
  int    errors = 0;
  bit    running = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  bootsel_decoder u_bootsel_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .busAddr(busAddr), .asN(asN), .dsN(dsN), .rdWr(rdWr), .upperEn(upperEn),
    .lowerEn(lowerEn), .fc(fc), .csN(csN), .dtackN(dtackN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mkOpt(int waits, int code, int lanes, int dir, int ds,
                               int sp, int lvl, int av);
    return waits | (code << 4) | (lanes << 8) | (dir << 10) | (ds << 12) |
           (sp << 13) | (lvl << 15) | (av << 18);
  endfunction

  localparam int RESET_OPT = (13) | (8 << 4) | (3 << 8) | (3 << 10) | (2 << 13);

  // Behavioural reference model.
  function automatic bit refHit(int base, int opt, int a, int f, bit rd, bit up, bit lo);
    int code, size, low, sp, lvl, dir, lanes;
    bit inRange, spOk, dirOk, laneOk;
    code = (opt >> 4) & 15;
    if (code > 9) code = 9;
    size = 2048 << code;
    low = (base / size) * size;
    inRange = (a >= low) && (a < low + size);
    sp = (opt >> 13) & 3;
    lvl = (opt >> 15) & 7;
    case (sp)
      0: spOk = (f == 7) && (lvl == 0 || ((a >> 1) & 7) == lvl);
      1: spOk = (f < 4);
      2: spOk = (f >= 4) && (f != 7);
      default: spOk = (f != 7);
    endcase
    dir = (opt >> 10) & 3;
    dirOk = rd ? dir[0] : dir[1];
    lanes = (opt >> 8) & 3;
    laneOk = (up && lanes[1]) || (lo && lanes[0]);
    return inRange && spOk && dirOk && laneOk;
  endfunction

  function automatic bit refAckOk(int opt);
    return ((opt & 15) != 15) && !((((opt >> 13) & 3) == 0) && (((opt >> 18) & 1) == 1));
  endfunction

  int mBase, mOpt, aBase, aOpt, kEdge;
  bit inCyc, alive, h, strobeOk;
  bit expCs = 1, expAck = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      mBase = 0; mOpt = RESET_OPT; aBase = 0; aOpt = RESET_OPT;
      inCyc = 0; alive = 0; kEdge = 0; expCs = 1; expAck = 1;
    end else begin
      h = refHit(aBase, aOpt, int'(busAddr), int'(fc), rdWr, upperEn, lowerEn);
      strobeOk = !asN && ((((aOpt >> 12) & 1) == 0) || !dsN);
      expCs = !(h && strobeOk);
      if (asN) begin
        expAck = 1; inCyc = 0;
        aBase = mBase; aOpt = mOpt;
      end else begin
        if (!inCyc) begin inCyc = 1; kEdge = 0; alive = 1; end
        else kEdge++;
        if (!h) alive = 0;
        expAck = !(alive && refAckOk(aOpt) && kEdge >= (aOpt & 15));
      end
      if (cfgWrEn) begin
        if (cfgSel) mOpt = int'(cfgData[18:0]);
        else        mBase = int'(cfgData);
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      check(csN == expCs, curReq, "csN vs model", csN, expCs);
      check(dtackN == expAck, curReq, "dtackN vs model", dtackN, expAck);
    end
  end

  task automatic cfgWrite(input bit sel, input int data);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgData = 24'(data);
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic busCycle(input int a, input int f, input bit rd, input bit up, input bit lo,
                          input int dsLag, input bit midWr, input bit mSel, input int mData,
                          output int csAt, output int ackAt);
    @(negedge clk);
    busAddr = 24'(a); fc = 3'(f); rdWr = rd; upperEn = up; lowerEn = lo;
    asN = 0; dsN = (dsLag == 0) ? 1'b0 : 1'b1;
    csAt = -1; ackAt = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!csN && csAt < 0) csAt = i;
      if (!dtackN && ackAt < 0) ackAt = i;
      if (i + 1 == dsLag) dsN = 0;
      if (midWr && i == 1) begin
        cfgWrEn = 1; cfgSel = mSel; cfgData = 24'(mData);
      end else cfgWrEn = 0;
    end
    asN = 1; dsN = 1; cfgWrEn = 0;
    @(negedge clk);
    check(csN && dtackN, "R4", "release after asN high", {csN, dtackN}, 3);
  endtask

  task automatic expectCycle(input string req, input int a, input int f, input bit rd,
                             input bit up, input bit lo, input int dsLag,
                             input int expCsAt, input int expAckAt);
    int cA, aA;
    curReq = req;
    busCycle(a, f, rd, up, lo, dsLag, 0, 0, 0, cA, aA);
    check(cA == expCsAt, req, $sformatf("select edge at 0x%06h", a), cA, expCsAt);
    check(aA == expAckAt, req, $sformatf("ack edge at 0x%06h", a), aA, expAckAt);
  endtask

  initial begin
    int cA, aA;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(csN == 1 && dtackN == 1, "R1", "outputs held in reset", {csN, dtackN}, 3);
    rstN = 1; running = 1;

    // R1 R3: boot fetch
    expectCycle("R1", 0, 6, 1, 1, 1, 0, 0, 13);
    // R2: window edges
    expectCycle("R2", 24'h07FFFF, 5, 0, 1, 1, 0, 0, 13);
    expectCycle("R2", 24'h080000, 6, 1, 1, 1, 0, -1, -1);
    // R5: user and cpu spaces rejected
    expectCycle("R5", 24'h000100, 2, 1, 1, 1, 0, -1, -1);
    expectCycle("R5", 24'h000100, 7, 1, 1, 1, 0, -1, -1);
    // R7: reset lanes
    expectCycle("R7", 24'h000200, 6, 1, 0, 1, 0, 0, 13);
    expectCycle("R7", 24'h000200, 6, 1, 1, 0, 0, 0, 13);

    // R6 R11: 2 KB window, zero waits
    cfgWrite(0, 24'h123456);
    cfgWrite(1, mkOpt(0, 0, 3, 3, 0, 2, 0, 0));
    expectCycle("R6", 24'h1237FF, 6, 1, 1, 1, 0, 0, 0);
    expectCycle("R6", 24'h123000, 6, 1, 1, 1, 0, 0, 0);
    expectCycle("R6", 24'h123800, 6, 1, 1, 1, 0, -1, -1);
    expectCycle("R6", 24'h122FFF, 6, 1, 1, 1, 0, -1, -1);

    // R6: code above 9 clamps to 1 MB
    cfgWrite(1, mkOpt(2, 12, 3, 3, 0, 2, 0, 0));
    expectCycle("R6", 24'h1FFFFF, 6, 1, 1, 1, 0, 0, 2);
    expectCycle("R6", 24'h100000, 6, 1, 1, 1, 0, 0, 2);
    expectCycle("R6", 24'h200000, 6, 1, 1, 1, 0, -1, -1);

    // R7: lower lane only, reads only
    cfgWrite(1, mkOpt(1, 12, 1, 1, 0, 2, 0, 0));
    expectCycle("R7", 24'h100010, 6, 1, 1, 0, 0, -1, -1);
    expectCycle("R7", 24'h100010, 6, 1, 0, 1, 0, 0, 1);
    expectCycle("R7", 24'h100010, 6, 0, 0, 1, 0, -1, -1);

    // R8: data-strobe timing
    cfgWrite(1, mkOpt(1, 12, 3, 3, 1, 2, 0, 0));
    expectCycle("R8", 24'h100020, 6, 1, 1, 1, 3, 3, 1);

    // R9: level and autovector ignored outside cpu space
    cfgWrite(1, mkOpt(2, 12, 3, 3, 0, 2, 3, 1));
    expectCycle("R9", 24'h100000, 6, 1, 1, 1, 0, 0, 2);
    cfgWrite(1, mkOpt(2, 12, 3, 3, 0, 0, 3, 0));
    expectCycle("R9", 24'h100006, 7, 1, 1, 1, 0, 0, 2);
    expectCycle("R9", 24'h100004, 7, 1, 1, 1, 0, -1, -1);
    expectCycle("R9", 24'h100006, 6, 1, 1, 1, 0, -1, -1);
    cfgWrite(1, mkOpt(2, 12, 3, 3, 0, 0, 3, 1));
    expectCycle("R9", 24'h100006, 7, 1, 1, 1, 0, 0, -1);
    cfgWrite(1, mkOpt(2, 12, 3, 3, 0, 0, 0, 0));
    expectCycle("R9", 24'h10000A, 7, 1, 1, 1, 0, 0, 2);

    // R10: write inside a cycle governs the next one
    cfgWrite(1, mkOpt(5, 12, 3, 3, 0, 2, 0, 0));
    curReq = "R10";
    busCycle(24'h100040, 6, 1, 1, 1, 0, 1, 1, mkOpt(1, 12, 3, 3, 0, 2, 0, 0), cA, aA);
    check(aA == 5, "R10", "ack edge during write", aA, 5);
    expectCycle("R10", 24'h100040, 6, 1, 1, 1, 0, 0, 1);

    // R11: wait count 15 disables the acknowledge
    cfgWrite(1, mkOpt(15, 12, 3, 3, 0, 2, 0, 0));
    expectCycle("R11", 24'h100080, 6, 1, 1, 1, 0, 0, -1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule